// File: doc/BRIEF.md
# Accumulator ALU with Condition Flags

This block is the arithmetic and logic datapath of an 8-bit accumulator machine. Each cycle it takes the accumulator, a second operand and an operation code. It produces the result, the next value of the condition flags and a write-back enable. The result path is purely combinational.

A registered flag byte sits beside the datapath and holds sign, zero, auxiliary carry, parity and carry. The stored carry and auxiliary carry feed back into the operations that need them: carry-in, borrow-in, rotates through carry, carry complement and decimal adjust. The flag byte loads only when the surrounding control asserts the flag-update enable.

Each group of operations writes its own subset of the flags. Compare computes a subtraction but suppresses write-back of the result. Decimal adjust corrects a packed-BCD sum using the stored auxiliary carry and carry.

Top module: `acc_alu`

## Requirements
- R1: The stored flag byte has sign at bit 7, zero at bit 6, auxiliary carry at bit 4, parity at bit 2 and carry at bit 0. Bit 1 always reads 1, and bits 3 and 5 always read 0. After a synchronous reset the byte is 8'h02. The same layout applies to the next-flags output.
- R2: Op 0 (add) and op 1 (add with carry) give the result acc+opnd, plus the stored carry for op 1. Carry is the carry out of bit 7 and auxiliary carry is the carry out of bit 3. Sign, zero and parity come from the result.
- R3: Op 2 (subtract) and op 3 (subtract with borrow) give acc-opnd, minus the stored carry for op 3. Carry is 1 when the full subtraction borrows, and auxiliary carry is 1 when the low nibble borrows. Sign, zero and parity come from the result.
- R4: Op 7 (compare) sets all five flags exactly as op 2 would. It holds the write-back enable low.
- R5: Op 4 (AND) gives acc&opnd with carry cleared. Auxiliary carry is acc[3] OR opnd[3]. Sign, zero and parity come from the result.
- R6: Op 6 (OR) and op 5 (XOR) clear both carry and auxiliary carry. Sign, zero and parity come from the result.
- R7: Op 8 (increment) and op 9 (decrement) act on the operand input. Auxiliary carry flags a carry out of, or a borrow into, the low nibble. Sign, zero and parity are updated and carry is left unchanged.
- R8: Op 10 gives the complement of the accumulator and leaves every flag unchanged.
- R9: Op 15 forces carry to 1 and op 16 inverts carry. The result is the accumulator and no other flag changes.
- R10: Op 11 rotates the accumulator left circular and op 12 rotates it right circular; the bit that leaves also enters carry. Op 13 rotates left through carry and op 14 rotates right through carry, treating carry as a ninth bit. All four change only carry.
- R11: Op 17 (decimal adjust) first adds 0x06 when the low nibble exceeds 9 or the stored auxiliary carry is 1. It then adds 0x60 when the intermediate high nibble exceeds 9 or the stored carry is 1. Carry becomes 1 exactly when the second step applies, and auxiliary carry is the carry out of bit 3 of the first step.
- R12: The flag byte loads the next-flags value at a clock edge only when the flag-update enable is high and otherwise holds. Op codes 18 to 31 return the accumulator, hold write-back low and leave the next flags equal to the stored ones.
- R13: Parity is 1 when the result holds an even number of one bits. Write-back is high for every defined op except compare.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_i | input | 8 | Accumulator operand |
| opnd_i | input | 8 | Second operand |
| op_i | input | 5 | Operation code |
| flag_we_i | input | 1 | Flag-update enable |
| result_o | output | 8 | Combinational result |
| flags_next_o | output | 8 | Next flag byte |
| wb_en_o | output | 1 | Result write-back enable |
| flags_o | output | 8 | Stored flag byte |

## Verification
The bench goes after the points where a flag sits on a nibble or byte boundary. These include 0xFF+0x01, 0x00-0x01, increment of 0x0F and 0xFF, decrement of 0x00, and decimal adjust of 0x9A and of values with a stored auxiliary carry. A design that inverted borrow polarity, or took auxiliary carry from the wrong bit, would show the wrong carry or auxiliary carry there. Compare is checked for a suppressed write-back with the flags still loaded. Increment, rotates and complement are checked for leaking changes into flags they must keep. Runs with the flag enable low confirm that the stored byte holds, and undefined codes confirm they act as no-ops.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int DW = 8;
  localparam int NW = DW / 2;
  localparam int OPW = 5;

  localparam int FB_S  = 7;
  localparam int FB_Z  = 6;
  localparam int FB_AC = 4;
  localparam int FB_P  = 2;
  localparam int FB_CY = 0;
  localparam logic [DW-1:0] FL_FIXED_ONES = 8'h02;
  localparam logic [DW-1:0] FL_FIXED_MASK = 8'h2A;

  typedef enum logic [OPW-1:0] {
    OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBB = 5'd3,
    OP_AND = 5'd4,  OP_XOR = 5'd5,  OP_OR  = 5'd6,  OP_CMP = 5'd7,
    OP_INC = 5'd8,  OP_DEC = 5'd9,  OP_CPL = 5'd10, OP_RLC = 5'd11,
    OP_RRC = 5'd12, OP_RLT = 5'd13, OP_RRT = 5'd14, OP_SCF = 5'd15,
    OP_CCF = 5'd16, OP_DAJ = 5'd17
  } alu_op_e;
endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub
  import acc_alu_pkg::*;
(
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          sub_i,
  input  logic          use_cy_i,
  input  logic          cy_i,
  output logic [DW-1:0] sum_o,
  output logic          cy_o,
  output logic          ac_o
);
  logic          cin;
  logic [DW-1:0] b_eff;
  logic [DW:0]   full;
  logic [NW:0]   low;

  always_comb begin
    b_eff = sub_i ? ~b_i : b_i;
    cin   = sub_i ? ~(use_cy_i & cy_i) : (use_cy_i & cy_i);
    full  = {1'b0, a_i} + {1'b0, b_eff} + {{DW{1'b0}}, cin};
    low   = {1'b0, a_i[NW-1:0]} + {1'b0, b_eff[NW-1:0]} + {{NW{1'b0}}, cin};
    sum_o = full[DW-1:0];
    // a carry out of the complemented sum means no borrow
    cy_o  = full[DW] ^ sub_i;
    ac_o  = low[NW] ^ sub_i;
  end
endmodule

// File: rtl/acc_alu_incdec.sv
module acc_alu_incdec
  import acc_alu_pkg::*;
(
  input  logic [DW-1:0] b_i,
  input  logic          dec_i,
  output logic [DW-1:0] res_o,
  output logic          ac_o
);
  localparam logic [DW-1:0] ONE = DW'(1);

  always_comb begin
    if (dec_i) begin
      res_o = b_i - ONE;
      ac_o  = (b_i[NW-1:0] == '0);
    end else begin
      res_o = b_i + ONE;
      ac_o  = (b_i[NW-1:0] == '1);
    end
  end
endmodule

// File: rtl/acc_alu_bitops.sv
module acc_alu_bitops
  import acc_alu_pkg::*;
(
  input  logic [DW-1:0]  a_i,
  input  logic [DW-1:0]  b_i,
  input  alu_op_e        op_i,
  input  logic           cy_i,
  output logic [DW-1:0]  res_o,
  output logic           cy_o
);
  always_comb begin
    res_o = a_i;
    cy_o  = cy_i;
    unique case (op_i)
      OP_AND: res_o = a_i & b_i;
      OP_OR:  res_o = a_i | b_i;
      OP_XOR: res_o = a_i ^ b_i;
      OP_CPL: res_o = ~a_i;
      OP_RLC: begin res_o = {a_i[DW-2:0], a_i[DW-1]}; cy_o = a_i[DW-1]; end
      OP_RRC: begin res_o = {a_i[0], a_i[DW-1:1]};    cy_o = a_i[0];    end
      OP_RLT: begin res_o = {a_i[DW-2:0], cy_i};      cy_o = a_i[DW-1]; end
      OP_RRT: begin res_o = {cy_i, a_i[DW-1:1]};      cy_o = a_i[0];    end
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_alu_decadj.sv
module acc_alu_decadj
  import acc_alu_pkg::*;
(
  input  logic [DW-1:0] a_i,
  input  logic          ac_i,
  input  logic          cy_i,
  output logic [DW-1:0] res_o,
  output logic          ac_o,
  output logic          cy_o
);
  localparam logic [DW:0] LO_FIX = 9'h006;
  localparam logic [DW:0] HI_FIX = 9'h060;
  localparam logic [NW-1:0] NINE = 4'd9;

  logic        lo_hit;
  logic        hi_hit;
  logic [NW:0] lo_sum;
  logic [DW:0] mid;
  logic [DW:0] fin;

  always_comb begin
    lo_hit = (a_i[NW-1:0] > NINE) | ac_i;
    lo_sum = {1'b0, a_i[NW-1:0]} + (lo_hit ? 5'd6 : 5'd0);
    mid    = {1'b0, a_i} + (lo_hit ? LO_FIX : '0);
    hi_hit = mid[DW] | (mid[DW-1:NW] > NINE) | cy_i;
    fin    = mid + (hi_hit ? HI_FIX : '0);
    res_o  = fin[DW-1:0];
    ac_o   = lo_sum[NW];
    cy_o   = hi_hit;
  end
endmodule

// File: rtl/acc_alu_flagreg.sv
module acc_alu_flagreg
  import acc_alu_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          we_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] q_o
);
  logic [DW-1:0] q;

  always_ff @(posedge clk) begin
    if (rst)       q <= FL_FIXED_ONES;
    else if (we_i) q <= (d_i & ~FL_FIXED_MASK) | FL_FIXED_ONES;
  end

  assign q_o = q;
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic [7:0]    acc_i,
  input  logic [7:0]    opnd_i,
  input  logic [4:0]    op_i,
  input  logic          flag_we_i,
  output logic [7:0]    result_o,
  output logic [7:0]    flags_next_o,
  output logic          wb_en_o,
  output logic [7:0]    flags_o
);
  alu_op_e       op;
  logic [DW-1:0] fl_q;
  logic          cy_q, ac_q;

  logic [DW-1:0] as_res, id_res, bo_res, da_res;
  logic          as_cy, as_ac, id_ac, bo_cy, da_ac, da_cy;
  logic          is_sub, use_cy;

  logic [DW-1:0] res;
  logic          n_s, n_z, n_ac, n_p, n_cy, szp_upd, wb;

  assign op   = alu_op_e'(op_i);
  assign cy_q = fl_q[FB_CY];
  assign ac_q = fl_q[FB_AC];

  assign is_sub = (op == OP_SUB) || (op == OP_SBB) || (op == OP_CMP);
  assign use_cy = (op == OP_ADC) || (op == OP_SBB);

  acc_alu_addsub u_addsub (
    .a_i(acc_i), .b_i(opnd_i), .sub_i(is_sub), .use_cy_i(use_cy), .cy_i(cy_q),
    .sum_o(as_res), .cy_o(as_cy), .ac_o(as_ac)
  );

  acc_alu_incdec u_incdec (
    .b_i(opnd_i), .dec_i(op == OP_DEC), .res_o(id_res), .ac_o(id_ac)
  );

  acc_alu_bitops u_bitops (
    .a_i(acc_i), .b_i(opnd_i), .op_i(op), .cy_i(cy_q),
    .res_o(bo_res), .cy_o(bo_cy)
  );

  acc_alu_decadj u_decadj (
    .a_i(acc_i), .ac_i(ac_q), .cy_i(cy_q),
    .res_o(da_res), .ac_o(da_ac), .cy_o(da_cy)
  );

  always_comb begin
    res     = acc_i;
    n_ac    = ac_q;
    n_cy    = cy_q;
    szp_upd = 1'b0;
    wb      = 1'b1;
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
        res = as_res; n_cy = as_cy; n_ac = as_ac; szp_upd = 1'b1;
      end
      OP_CMP: begin
        res = as_res; n_cy = as_cy; n_ac = as_ac; szp_upd = 1'b1; wb = 1'b0;
      end
      OP_AND: begin
        res = bo_res; n_cy = 1'b0; n_ac = acc_i[3] | opnd_i[3]; szp_upd = 1'b1;
      end
      OP_OR, OP_XOR: begin
        res = bo_res; n_cy = 1'b0; n_ac = 1'b0; szp_upd = 1'b1;
      end
      OP_INC, OP_DEC: begin
        res = id_res; n_ac = id_ac; szp_upd = 1'b1;
      end
      OP_CPL: res = bo_res;
      OP_RLC, OP_RRC, OP_RLT, OP_RRT: begin
        res = bo_res; n_cy = bo_cy;
      end
      OP_SCF: n_cy = 1'b1;
      OP_CCF: n_cy = ~cy_q;
      OP_DAJ: begin
        res = da_res; n_cy = da_cy; n_ac = da_ac; szp_upd = 1'b1;
      end
      default: wb = 1'b0;
    endcase
    n_s = szp_upd ? res[DW-1]   : fl_q[FB_S];
    n_z = szp_upd ? (res == '0) : fl_q[FB_Z];
    n_p = szp_upd ? ~^res       : fl_q[FB_P];
  end

  always_comb begin
    flags_next_o        = FL_FIXED_ONES;
    flags_next_o[FB_S]  = n_s;
    flags_next_o[FB_Z]  = n_z;
    flags_next_o[FB_AC] = n_ac;
    flags_next_o[FB_P]  = n_p;
    flags_next_o[FB_CY] = n_cy;
  end

  acc_alu_flagreg u_flagreg (
    .clk(clk), .rst(rst), .we_i(flag_we_i), .d_i(flags_next_o), .q_o(fl_q)
  );

  assign result_o = res;
  assign wb_en_o  = wb;
  assign flags_o  = fl_q;
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk (
  input logic       clk,
  input logic       rst,
  input logic [7:0] acc_i,
  input logic [4:0] op_i,
  input logic       flag_we_i,
  input logic [7:0] result_o,
  input logic [7:0] flags_next_o,
  input logic       wb_en_o,
  input logic [7:0] flags_o
);
  // R1: fixed bits of the stored byte
  a_r1_fixed_bits: assert property (@(posedge clk) disable iff (rst)
    flags_o[1] && !flags_o[3] && !flags_o[5]);

  // R4: compare never writes back
  a_r4_cmp_no_wb: assert property (@(posedge clk) disable iff (rst)
    (op_i == 5'd7) |-> !wb_en_o);

  // R12: hold when the enable is low
  a_r12_hold: assert property (@(posedge clk) disable iff (rst)
    !flag_we_i |=> $stable(flags_o));

  // R12: load when the enable is high
  a_r12_load: assert property (@(posedge clk) disable iff (rst)
    flag_we_i |=> (flags_o == $past(flags_next_o)));

  // R10: rotates touch carry only
  a_r10_rot_only_cy: assert property (@(posedge clk) disable iff (rst)
    (op_i >= 5'd11 && op_i <= 5'd14) |-> (flags_next_o[7:1] == flags_o[7:1]));

  // R6: OR and XOR clear both carries
  a_r6_clear_carries: assert property (@(posedge clk) disable iff (rst)
    (op_i == 5'd5 || op_i == 5'd6) |-> (!flags_next_o[4] && !flags_next_o[0]));

  // R7: increment and decrement keep carry
  a_r7_keep_cy: assert property (@(posedge clk) disable iff (rst)
    (op_i == 5'd8 || op_i == 5'd9) |-> (flags_next_o[0] == flags_o[0]));

  // R8: complement keeps every flag
  a_r8_cpl_keep: assert property (@(posedge clk) disable iff (rst)
    (op_i == 5'd10) |-> (flags_next_o == flags_o));

  // R12: undefined codes pass the accumulator through
  a_r12_undef_nop: assert property (@(posedge clk) disable iff (rst)
    (op_i > 5'd17) |-> (result_o == acc_i && !wb_en_o && flags_next_o == flags_o));
endmodule

bind acc_alu acc_alu_chk u_chk (
  .clk(clk), .rst(rst), .acc_i(acc_i), .op_i(op_i), .flag_we_i(flag_we_i),
  .result_o(result_o), .flags_next_o(flags_next_o), .wb_en_o(wb_en_o),
  .flags_o(flags_o)
);

// File: tb/acc_alu_tb.sv
module acc_alu_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] acc_i = '0, opnd_i = '0;
  logic [4:0] op_i = '0;
  logic       flag_we_i = 1'b0;
  logic [7:0] result_o, flags_next_o, flags_o;
  logic       wb_en_o;

  int n_checks = 0;
  int n_fail   = 0;
  logic [7:0] model_fl;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_alu u_dut (
    .clk(clk), .rst(rst), .acc_i(acc_i), .opnd_i(opnd_i), .op_i(op_i),
    .flag_we_i(flag_we_i), .result_o(result_o), .flags_next_o(flags_next_o),
    .wb_en_o(wb_en_o), .flags_o(flags_o)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input int op);
    case (op)
      0, 1: return "R2";
      2, 3: return "R3";
      7: return "R4";
      4: return "R5";
      5, 6: return "R6";
      8, 9: return "R7";
      10: return "R8";
      15, 16: return "R9";
      11, 12, 13, 14: return "R10";
      17: return "R11";
      default: return "R12";
    endcase
  endfunction

  function automatic logic par_even(input int v);
    int c = 0;
    for (int i = 0; i < 8; i++) if ((v >> i) & 1) c++;
    return (c % 2) == 0;
  endfunction

  task automatic ref_model(input int a, input int b, input int op, input logic [7:0] fl,
                           output int r, output logic [7:0] nf, output logic wb);
    int cy, ac, ncy, nac, t, cin;
    logic szp, lc, hc;
    cy = fl[0]; ac = fl[4]; ncy = cy; nac = ac; szp = 0; wb = 1; r = a;
    case (op)
      0, 1: begin
        cin = (op == 1) ? cy : 0;
        t = a + b + cin; r = t & 255; ncy = t > 255;
        nac = ((a & 15) + (b & 15) + cin) > 15; szp = 1;
      end
      2, 3, 7: begin
        cin = (op == 3) ? cy : 0;
        t = a - b - cin; r = t & 255; ncy = t < 0;
        nac = ((a & 15) - (b & 15) - cin) < 0; szp = 1;
        if (op == 7) wb = 0;
      end
      4: begin r = a & b; ncy = 0; nac = ((a | b) >> 3) & 1; szp = 1; end
      5: begin r = a ^ b; ncy = 0; nac = 0; szp = 1; end
      6: begin r = a | b; ncy = 0; nac = 0; szp = 1; end
      8: begin r = (b + 1) & 255; nac = (b & 15) == 15; szp = 1; end
      9: begin r = (b + 255) & 255; nac = (b & 15) == 0; szp = 1; end
      10: r = (~a) & 255;
      11: begin r = ((a << 1) | (a >> 7)) & 255; ncy = (a >> 7) & 1; end
      12: begin r = (a >> 1) | ((a & 1) << 7); ncy = a & 1; end
      13: begin r = ((a << 1) | cy) & 255; ncy = (a >> 7) & 1; end
      14: begin r = (a >> 1) | (cy << 7); ncy = a & 1; end
      15: ncy = 1;
      16: ncy = 1 - cy;
      17: begin
        t = a; lc = ((a & 15) > 9) || ac;
        nac = lc && (((a & 15) + 6) > 15);
        if (lc) t = t + 6;
        hc = ((t >> 4) > 9) || cy;
        if (hc) t = t + 'h60;
        ncy = hc; r = t & 255; szp = 1;
      end
      default: wb = 0;
    endcase
    nf = fl;
    nf[0] = ncy[0]; nf[4] = nac[0];
    if (szp) begin nf[7] = r[7]; nf[6] = (r == 0); nf[2] = par_even(r); end
    nf[1] = 1; nf[3] = 0; nf[5] = 0;
  endtask

  task automatic step(input int a, input int b, input int op, input logic we);
    int r; logic [7:0] nf; logic wb; string tg;
    @(negedge clk);
    acc_i = a[7:0]; opnd_i = b[7:0]; op_i = op[4:0]; flag_we_i = we;
    #1;
    ref_model(a, b, op, model_fl, r, nf, wb);
    tg = tag_of(op);
    check(tg, "result", result_o, r);
    check(tg, "flags_next", flags_next_o, nf);
    check((op == 7 || op > 17) ? tg : "R13", "wb_en", wb_en_o, wb);
    if (op <= 4 || (op >= 5 && op <= 9) || op == 17)
      check("R13", "parity", flags_next_o[2], par_even(r));
    @(posedge clk); #1;
    if (we) model_fl = nf;
    check(we ? tg : "R12", "stored flags", flags_o, model_fl);
    check("R1", "fixed bits", {29'd0, flags_o[5], flags_o[3], flags_o[1]}, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    model_fl = 8'h02;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    check("R1", "reset flags", flags_o, 8'h02);
    // R2 byte and nibble carry, zero, parity of zero
    step(8'hFF, 8'h01, 0, 1);
    step(8'h10, 8'h20, 1, 1);     // R2 with stored carry 1
    step(8'h7F, 8'h01, 0, 1);
    // R3 borrows
    step(8'h00, 8'h01, 2, 1);
    step(8'h10, 8'h0F, 3, 1);     // R3 with stored borrow
    // R4 compare equal and less
    step(8'h42, 8'h42, 7, 1);
    step(8'h10, 8'h20, 7, 1);
    // R5, R6
    step(8'h08, 8'h00, 4, 1);
    step(8'hF0, 8'h0F, 4, 1);
    step(8'h81, 8'h18, 5, 1);
    step(8'h00, 8'h00, 6, 1);
    // R9 then R7 keeps carry
    step(8'h00, 8'h00, 15, 1);
    step(8'h00, 8'hFF, 8, 1);
    step(8'h00, 8'h0F, 8, 1);
    step(8'h00, 8'h00, 9, 1);
    step(8'h00, 8'h80, 9, 1);
    step(8'h00, 8'h00, 16, 1);
    step(8'h00, 8'h00, 16, 1);
    // R8
    step(8'h5A, 8'h00, 10, 1);
    // R10 with both carry values
    step(8'h81, 8'h00, 11, 1);
    step(8'h81, 8'h00, 12, 1);
    step(8'h80, 8'h00, 13, 1);
    step(8'h01, 8'h00, 14, 1);
    step(8'h02, 8'h00, 14, 1);
    // R11 decimal adjust cases
    step(8'h00, 8'h00, 6, 1);     // clear carries
    step(8'h9A, 8'h00, 17, 1);
    step(8'h00, 8'h00, 6, 1);
    step(8'h15, 8'h00, 17, 1);
    step(8'h09, 8'h08, 0, 1);     // sets AC, result 0x11
    step(8'h11, 8'h00, 17, 1);
    step(8'h99, 8'h99, 0, 1);     // sets CY and AC
    step(8'h32, 8'h00, 17, 1);
    // R12 hold with enable low, and undefined codes
    step(8'hFF, 8'h01, 0, 0);
    step(8'h00, 8'h01, 2, 0);
    step(8'h33, 8'h44, 20, 1);
    step(8'hAB, 8'h00, 31, 1);
    for (int i = 0; i < 3000; i++)
      step($urandom_range(0, 255), $urandom_range(0, 255), $urandom_range(0, 19),
           logic'($urandom_range(0, 3) != 0));
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule